// File: doc/BRIEF.md
# Command Register with Busy Flag

This block is a 16-bit command register that sits between a host and a microcoded engine. A single host write carries three things: an operation code, a channel number and a flag bit. When the flag bit is set, the write also acts as the launch strobe. The block accepts the write and sends a one-cycle start pulse to the addressed channel. The flag then reads back as set until the engine reports completion, and the hardware clears it at that point. The host learns that the command has finished by polling the flag. It can also watch a one-cycle done pulse.

A second control bit in the low nibble turns the write into an engine reinitialisation. The channel field is then not used. A separate reinit pulse is issued and no channel is started. The block ignores malformed writes, writes without the flag and writes that arrive while a command is in flight. A write of the last kind also sets a sticky overrun bit. The engine is a stub that completes after a fixed number of cycles, set by a parameter between 1 and 64. That keeps completion far below the host's polling limit of ten thousand reads.

Top module: `cmd_reg_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rd_data` is 0 and `busy`, `done`, `overrun`, `eng_reinit` and every `chan_start` bit are 0.
- R2: A write is well formed when bit 0 (flag) is 1 and bits 15:12 and 3:2 are 0. Such a write, presented while the block is idle, is accepted at that clock edge. From the next cycle, `rd_data` reads opcode in bits 11:8, channel in bits 7:4, the reinit bit in bit 1 and the flag as 1 in bit 0.
- R3: Accepting a channel command (bit 1 clear) drives exactly one bit of `chan_start`, the bit indexed by bits 7:4, for one cycle. That cycle is the first cycle after the accepting edge.
- R4: After a channel command is accepted, `busy` stays high for exactly RUN_CYCLES cycles and then falls. `done` is high for exactly the one cycle in which `busy` has just fallen.
- R5: A well-formed write with bit 1 set is a reinit command. It pulses `eng_reinit` for one cycle and drives no `chan_start` bit. `busy` stays high for exactly REINIT_CYCLES cycles, followed by the same `done` pulse.
- R6: A write with bit 0 clear has no effect on any output.
- R7: A write with any of bits 15:12 or 3:2 set has no effect on any output.
- R8: A channel command whose channel field is N_CHAN or larger has no effect. A reinit command is accepted whatever its channel field holds.
- R9: A well-formed write seen while `busy` is high has no effect on the command. This includes a write in the last busy cycle. Such a write sets `overrun`, which stays set until `rst`.
- R10: After completion, `rd_data` keeps the opcode, channel and reinit bit of the last accepted command, with bit 0 at 0. While `busy` is high, bits 15:1 do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write value |
| rd_data | output | 16 | Live flag in bit 0 and the last accepted command |
| busy | output | 1 | Command in flight (same as bit 0 of rd_data) |
| done | output | 1 | One-cycle completion pulse |
| overrun | output | 1 | Sticky: a legal write arrived while busy |
| chan_start | output | N_CHAN | One-hot, one-cycle channel launch pulse |
| eng_reinit | output | 1 | One-cycle engine reinitialisation pulse |

## Verification
The embedded assertions check, on every cycle, the properties that can be judged locally:
- `chan_start` is one-hot and rises only together with `busy`.
- `done` coincides exactly with the falling edge of `busy`.
- A reinit launch never starts a channel.
- `overrun` never clears on its own.
- The held command is frozen while the engine runs, and ignored writes leave it alone.

Only the bench scenarios can show the rest:
- that the exact busy length matches each latency parameter;
- that each malformed pattern is rejected;
- that the channel-range boundary falls at N_CHAN;
- that a write landing on the completion edge is still refused.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int REG_W    = 16;
    localparam int OP_LSB   = 8;
    localparam int OP_W     = 4;
    localparam int CH_LSB   = 4;
    localparam int CH_W     = 4;
    localparam int FLAG_BIT = 0;
    localparam int RST_BIT  = 1;
    localparam logic [REG_W-1:0] RSVD_MASK = 16'hF00C;

    typedef logic [OP_W-1:0] opcode_t;
    typedef logic [CH_W-1:0] chan_t;

    typedef struct packed {
        opcode_t op;
        chan_t   chan;
        logic    reinit;
    } cmd_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;

    function automatic cmd_t unpack_cmd(input logic [REG_W-1:0] w);
        cmd_t c;
        c.op     = w[OP_LSB +: OP_W];
        c.chan   = w[CH_LSB +: CH_W];
        c.reinit = w[RST_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_view(input cmd_t c, input logic flag);
        logic [REG_W-1:0] v;
        v                  = '0;
        v[OP_LSB +: OP_W]  = c.op;
        v[CH_LSB +: CH_W]  = c.chan;
        v[RST_BIT]         = c.reinit;
        v[FLAG_BIT]        = flag;
        return v;
    endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import cmdreg_pkg::*;
#(
    parameter int N_CHAN = 12
) (
    input  logic [REG_W-1:0] word,
    output cmd_t             cmd,
    output logic             well_formed
);

    logic rsvd_clear;
    logic chan_ok;

    always_comb begin
        cmd         = unpack_cmd(word);
        rsvd_clear  = ((word & RSVD_MASK) == '0);
        chan_ok     = cmd.reinit || (int'(cmd.chan) < N_CHAN);
        well_formed = word[FLAG_BIT] && rsvd_clear && chan_ok;
    end

endmodule

// File: rtl/cmd_engine_stub.sv
module cmd_engine_stub
    import cmdreg_pkg::*;
#(
    parameter int RUN_CYCLES    = 5,
    parameter int REINIT_CYCLES = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic launch_reinit,
    output logic busy,
    output logic finish
);

    localparam int MAX_LAT = (RUN_CYCLES > REINIT_CYCLES) ? RUN_CYCLES : REINIT_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam logic [CNT_W-1:0] RUN_LD    = CNT_W'(RUN_CYCLES);
    localparam logic [CNT_W-1:0] REINIT_LD = CNT_W'(REINIT_CYCLES);
    localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(1);

    initial begin
        a_run_range_r4: assert (RUN_CYCLES >= 1 && RUN_CYCLES <= 64)
            else $error("RUN_CYCLES out of range");
        a_reinit_range_r5: assert (REINIT_CYCLES >= 1 && REINIT_CYCLES <= 64)
            else $error("REINIT_CYCLES out of range");
    end

    eng_state_t       state;
    logic [CNT_W-1:0] remain;

    assign busy   = (state == ENG_RUN);
    assign finish = busy && (remain == LAST_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            remain <= '0;
        end else if (launch && !busy) begin
            state  <= ENG_RUN;
            remain <= launch_reinit ? REINIT_LD : RUN_LD;
        end else if (busy) begin
            remain <= remain - LAST_ONE;
            if (remain == LAST_ONE) begin
                state <= ENG_IDLE;
            end
        end
    end

    // R4: a running engine always has cycles left to count
    p_remain_live_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (remain != '0));

    // R9: the register never launches into a running engine
    p_launch_idle_r9: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy);

    // R4: the last counted cycle ends the run
    p_finish_clears_r4: assert property (@(posedge clk) disable iff (rst)
        finish |=> !busy);

endmodule

// File: rtl/cmd_chan_fanout.sv
module cmd_chan_fanout
    import cmdreg_pkg::*;
#(
    parameter int N_CHAN = 12
) (
    input  logic              fire,
    input  chan_t             chan,
    output logic [N_CHAN-1:0] hit
);

    for (genvar g = 0; g < N_CHAN; g++) begin : g_lane
        assign hit[g] = fire && (chan == chan_t'(g));
    end

endmodule

// File: rtl/cmd_reg_ctrl.sv
module cmd_reg_ctrl
    import cmdreg_pkg::*;
#(
    parameter int N_CHAN        = 12,
    parameter int RUN_CYCLES    = 5,
    parameter int REINIT_CYCLES = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              busy,
    output logic              done,
    output logic              overrun,
    output logic [N_CHAN-1:0] chan_start,
    output logic              eng_reinit
);

    cmd_t              req_cmd;
    cmd_t              held_cmd;
    logic              well_formed;
    logic              take;
    logic              clash;
    logic              eng_busy;
    logic              eng_finish;
    logic [N_CHAN-1:0] start_hits;
    logic              done_q;
    logic              overrun_q;
    logic              reinit_q;
    logic [N_CHAN-1:0] start_q;

    cmd_decode #(.N_CHAN(N_CHAN)) u_dec (
        .word        (wr_data),
        .cmd         (req_cmd),
        .well_formed (well_formed)
    );

    assign take  = wr_en && well_formed && !eng_busy;
    assign clash = wr_en && well_formed && eng_busy;

    cmd_engine_stub #(
        .RUN_CYCLES    (RUN_CYCLES),
        .REINIT_CYCLES (REINIT_CYCLES)
    ) u_eng (
        .clk           (clk),
        .rst           (rst),
        .launch        (take),
        .launch_reinit (req_cmd.reinit),
        .busy          (eng_busy),
        .finish        (eng_finish)
    );

    cmd_chan_fanout #(.N_CHAN(N_CHAN)) u_fan (
        .fire (take && !req_cmd.reinit),
        .chan (req_cmd.chan),
        .hit  (start_hits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_cmd  <= '0;
            overrun_q <= 1'b0;
            done_q    <= 1'b0;
            reinit_q  <= 1'b0;
            start_q   <= '0;
        end else begin
            if (take) begin
                held_cmd <= req_cmd;
            end
            if (clash) begin
                overrun_q <= 1'b1;
            end
            done_q   <= eng_finish;
            reinit_q <= take && req_cmd.reinit;
            start_q  <= start_hits;
        end
    end

    assign rd_data    = pack_view(held_cmd, eng_busy);
    assign busy       = eng_busy;
    assign done       = done_q;
    assign overrun    = overrun_q;
    assign chan_start = start_q;
    assign eng_reinit = reinit_q;

    // R3: at most one channel is launched at a time
    p_start_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_start));

    // R3: a channel launch coincides with the flag going up
    p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (|chan_start) |-> $rose(busy));

    // R4: done only in the cycle the flag has just dropped
    p_done_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R4: every drop of the flag produces done
    p_fall_gives_done_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R5: a reinit never launches a channel
    p_reinit_no_start_r5: assert property (@(posedge clk) disable iff (rst)
        eng_reinit |-> (chan_start == '0));

    // R9: overrun is sticky
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R9: a write seen while busy leaves the held command alone
    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> $stable(rd_data[15:1]));

    // R6: a write without the flag changes nothing while idle
    p_noflag_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[0] && !busy) |=> ($stable(rd_data) && !busy));

    // R10: the held command is frozen while the engine runs
    p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rd_data[15:1]));

endmodule

// File: tb/cmd_reg_ctrl_test.sv
module cmd_reg_ctrl_test;

    localparam int N_CHAN        = 12;
    localparam int RUN_CYCLES    = 5;
    localparam int REINIT_CYCLES = 9;
    localparam int N_VEC         = 9;

    // {write value, expected acceptance}
    localparam logic [16:0] VEC [N_VEC] = '{
        {16'h0351, 1'b1},   // R2 R3 R4 op3 ch5
        {16'h0A01, 1'b1},   // R3 ch0
        {16'h0FB1, 1'b1},   // R8 highest legal channel
        {16'h02C1, 1'b0},   // R8 channel 12 out of range
        {16'h0350, 1'b0},   // R6 flag clear
        {16'h1351, 1'b0},   // R7 bit 12 set
        {16'h0355, 1'b0},   // R7 bit 2 set
        {16'h07F3, 1'b1},   // R5 R8 reinit, channel 15 ignored
        {16'h0003, 1'b1}    // R5 reinit
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_data = '0;
    logic [15:0]       rd_data;
    logic              busy;
    logic              done;
    logic              overrun;
    logic [N_CHAN-1:0] chan_start;
    logic              eng_reinit;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_view = '0;

    always #2.5 clk = ~clk;

    cmd_reg_ctrl #(
        .N_CHAN        (N_CHAN),
        .RUN_CYCLES    (RUN_CYCLES),
        .REINIT_CYCLES (REINIT_CYCLES)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .busy       (busy),
        .done       (done),
        .overrun    (overrun),
        .chan_start (chan_start),
        .eng_reinit (eng_reinit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // Counts busy cycles from the first busy negedge and checks the done pulse.
    task automatic wait_done(input string req, input int exp_len);
        int n = 0;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk({req, " busy length"}, n, exp_len);
        chk({req, " done on fall"}, {31'b0, done}, 1);
        @(negedge clk);
        chk({req, " done one cycle"}, {31'b0, done}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 rd_data in reset", {16'b0, rd_data}, 0);
        chk("R1 busy in reset", {31'b0, busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", {rd_data, busy, done, overrun, eng_reinit, 12'b0},
            32'h0);
        chk("R1 chan_start after reset", {20'b0, chan_start}, 0);

        for (int i = 0; i < N_VEC; i++) begin
            logic [15:0] w;
            logic        acc;
            logic        rein;
            w    = VEC[i][16:1];
            acc  = VEC[i][0];
            rein = w[1];
            do_write(w);
            if (acc) begin
                chk("R2 read after accept", {16'b0, rd_data}, {16'b0, w});
                chk("R2 busy set", {31'b0, busy}, 1);
                if (rein) begin
                    chk("R5 reinit pulse", {31'b0, eng_reinit}, 1);
                    chk("R5 no channel start", {20'b0, chan_start}, 0);
                end else begin
                    chk("R3 channel start", {20'b0, chan_start},
                        32'(1) << w[7:4]);
                    chk("R3 no reinit", {31'b0, eng_reinit}, 0);
                end
                @(negedge clk);
                chk("R3 start one cycle", {19'b0, chan_start, eng_reinit}, 0);
                if (rein) wait_done("R5", REINIT_CYCLES - 1);
                else      wait_done("R4", RUN_CYCLES - 1);
                last_view = w & 16'hFFFE;
                chk("R10 held after done", {16'b0, rd_data}, {16'b0, last_view});
            end else begin
                chk("R6 R7 R8 rejected read", {16'b0, rd_data}, {16'b0, last_view});
                chk("R6 R7 R8 rejected busy", {31'b0, busy}, 0);
                chk("R6 R7 R8 rejected start", {19'b0, chan_start, eng_reinit}, 0);
                @(negedge clk);
                chk("R6 R7 R8 still idle", {15'b0, busy, rd_data}, {16'b0, last_view});
            end
        end
        chk("R9 no overrun yet", {31'b0, overrun}, 0);

        // R9: legal write in the middle of a run
        do_write(16'h0421);
        do_write(16'h0561);
        chk("R9 held unchanged", {16'b0, rd_data}, 32'h0421);
        chk("R9 overrun set", {31'b0, overrun}, 1);
        chk("R9 no second start", {20'b0, chan_start}, 0);
        wait_done("R9 first run", RUN_CYCLES - 2);
        chk("R10 view after run", {16'b0, rd_data}, 32'h0420);
        chk("R9 overrun sticky", {31'b0, overrun}, 1);

        // R9: write landing on the completion edge
        do_write(16'h0931);
        repeat (RUN_CYCLES - 2) @(negedge clk);
        do_write(16'h0B71);
        chk("R9 last-cycle write busy", {31'b0, busy}, 0);
        chk("R9 last-cycle write done", {31'b0, done}, 1);
        chk("R9 last-cycle write held", {16'b0, rd_data}, 32'h0930);
        @(negedge clk);
        chk("R9 last-cycle write no launch", {31'b0, busy}, 0);

        // R1: reset clears the sticky bit and the held command
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 overrun cleared", {31'b0, overrun}, 0);
        chk("R1 held cleared", {16'b0, rd_data}, 0);

        // R2 R4: accepted immediately again after reset
        do_write(16'h0C81);
        chk("R2 accept after reset", {16'b0, rd_data}, 32'h0C81);
        chk("R3 ch8 start", {20'b0, chan_start}, 32'h100);
        wait_done("R4 after reset", RUN_CYCLES);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule